// File: doc/BRIEF.md
# VLIW Execute-Packet Splitter

This block sits between instruction fetch and dispatch in a wide-issue core. It receives a fetch word of eight 32-bit instruction slots and hands it on as a sequence of issue groups. Each group is the set of instructions that go out together in one cycle. Bit 0 of every instruction word is a chaining flag. When the flag is 1, the next slot joins the same group. When the flag is 0, the group ends at that slot.

Each group appears as an 8-bit slot mask together with the unchanged fetch word. It stays on the outputs until the consumer takes it. Once the final group of a word has been taken, the block raises its ready signal to the fetch side and accepts the next word.

Top module: `ep_splitter`

## Requirements
- R1: After reset, `grp_valid` is 0 and `fp_ready` is 1.
- R2: A group covers a run of adjacent slots. The run starts at the first slot not yet issued, where slot 0 is the earliest, and ends at the first slot in that run whose bit 0 is 0. Consecutive groups of one packet never share a slot.
- R3: Slot 7 always closes a group, whatever the value of its bit 0, so a group never reaches into the next fetch word.
- R4: A word whose slots all have bit 0 set to 1 issues as one group with mask 8'hFF.
- R5: A word whose slots all have bit 0 cleared issues as eight groups with masks 8'h01, 8'h02, 8'h04 and so on up to 8'h80, in that order.
- R6: While `grp_valid` is 1 and `grp_accept` is 0, `grp_mask` and `grp_data` do not change.
- R7: `grp_data` carries the whole 256-bit fetch word as it was received, for every group of that word.
- R8: `fp_ready` is 0 while a word is held. A `fp_valid` presented during that time has no effect. In the cycle after the final group is accepted, `fp_ready` is 1.
- R9: A word is taken when `fp_valid` and `fp_ready` are both 1 at a clock edge. Its first group, starting at slot 0, is valid from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_valid | input | 1 | Fetch word offered |
| fp_data | input | 256 | Fetch word, slot k in bits 32k+31:32k |
| fp_ready | output | 1 | Splitter can take a new fetch word |
| grp_valid | output | 1 | An issue group is presented |
| grp_mask | output | 8 | Slots belonging to the presented group |
| grp_data | output | 256 | Fetch word the group belongs to |
| grp_accept | input | 1 | Consumer takes the presented group |

## Verification
The assertions assume that `grp_accept` is raised only while `grp_valid` is 1. They also assume that `fp_data` is meaningful only in a cycle where it is taken. The bench raises `grp_accept` only after it has seen a group presented. It drops the signal as soon as the edge has passed, so no accept is ever left pending over an empty output. The bench offers extra fetch words on purpose while a word is held, to show that the block ignores them at that time.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int CHAIN_BIT = 0;
  typedef enum logic {HOLD_EMPTY = 1'b0, HOLD_FULL = 1'b1} hold_e;
endpackage

// File: rtl/ep_slot_scan.sv
module ep_slot_scan #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain,
  input  logic [SW-1:0]    start,
  output logic [SLOTS-1:0] mask,
  output logic             last,
  output logic [SW-1:0]    next_start
);
  logic          stop;
  logic [SW-1:0] end_idx;

  always_comb begin
    mask    = '0;
    stop    = 1'b0;
    end_idx = start;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop && i >= int'(start)) begin
        mask[i] = 1'b1;
        end_idx = SW'(i);
        if (!chain[i] || i == SLOTS - 1) stop = 1'b1;
      end
    end
  end

  assign last       = (end_idx == SW'(SLOTS - 1));
  assign next_start = end_idx + SW'(1);
endmodule

// File: rtl/ep_pkt_reg.sv
module ep_pkt_reg #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  localparam int SW = $clog2(SLOTS),
  localparam int PW = SLOTS * IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_data,
  input  logic          advance,
  input  logic          last,
  input  logic [SW-1:0] next_start,
  output logic [PW-1:0] pkt,
  output logic          full,
  output logic [SW-1:0] start
);
  import ep_pkg::*;

  hold_e         st_q, st_d;
  logic [SW-1:0] start_q, start_d;
  logic [PW-1:0] pkt_q;

  always_comb begin
    st_d    = st_q;
    start_d = start_q;
    if (load) begin
      st_d    = HOLD_FULL;
      start_d = '0;
    end else if (advance) begin
      if (last) begin
        st_d    = HOLD_EMPTY;
        start_d = '0;
      end else begin
        start_d = next_start;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HOLD_EMPTY;
      start_q <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) pkt_q <= load_data;
  end

  assign pkt   = pkt_q;
  assign full  = (st_q == HOLD_FULL);
  assign start = start_q;

  // R9
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full && start == '0));
endmodule

// File: rtl/ep_splitter.sv
module ep_splitter #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  localparam int SW = $clog2(SLOTS),
  localparam int PW = SLOTS * IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_valid,
  input  logic [PW-1:0]    fp_data,
  output logic             fp_ready,
  output logic             grp_valid,
  output logic [SLOTS-1:0] grp_mask,
  output logic [PW-1:0]    grp_data,
  input  logic             grp_accept
);
  import ep_pkg::*;

  logic [PW-1:0]    pkt;
  logic             full, last, load, advance;
  logic [SW-1:0]    start, next_start;
  logic [SLOTS-1:0] chain, mask;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_chain
      assign chain[g] = pkt[g*IW + CHAIN_BIT];
    end
  endgenerate

  assign fp_ready = !full;
  assign load     = fp_valid && fp_ready;
  assign advance  = full && grp_accept;

  ep_slot_scan #(.SLOTS(SLOTS)) u_scan (
    .chain(chain), .start(start), .mask(mask),
    .last(last), .next_start(next_start)
  );

  ep_pkt_reg #(.SLOTS(SLOTS), .IW(IW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(fp_data),
    .advance(advance), .last(last), .next_start(next_start),
    .pkt(pkt), .full(full), .start(start)
  );

  assign grp_valid = full;
  assign grp_mask  = full ? mask : '0;
  assign grp_data  = pkt;

  // R2
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> grp_mask != '0);
  // R2
  groups_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_accept && !grp_mask[SLOTS-1]) |=>
      (grp_valid && (grp_mask & $past(grp_mask)) == '0));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_accept) |=> ($stable(grp_mask) && $stable(grp_data)));
  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fp_ready && grp_valid));
  // R8
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_accept && grp_mask[SLOTS-1]) |=> fp_ready);
endmodule

// File: tb/sim_ep_splitter.sv
module sim_ep_splitter;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         fp_valid, grp_accept;
  logic [255:0] fp_data;
  logic         fp_ready, grp_valid;
  logic [7:0]   grp_mask;
  logic [255:0] grp_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ep_splitter u0 (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_data(fp_data),
    .fp_ready(fp_ready), .grp_valid(grp_valid), .grp_mask(grp_mask),
    .grp_data(grp_data), .grp_accept(grp_accept)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_pkt(input logic [7:0] pb, input logic [31:0] seed);
    logic [255:0] p;
    for (int k = 0; k < 8; k++)
      p[k*32 +: 32] = {(seed * 32'(k + 3) + 32'h1234_5678) ^ {k[3:0], 28'h0}} & 32'hFFFF_FFFE
                      | {31'b0, pb[k]};
    return p;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_pkt(input logic [255:0] p, input string req);
    chk(req, fp_ready, 1'b1);
    fp_valid = 1'b1; fp_data = p;
    tick();
    fp_valid = 1'b0;
    chk(req, grp_valid, 1'b1);
  endtask

  // Walk all groups of a packet, checking mask sequence and data (R2, R3, R7)
  task automatic run_groups(input logic [7:0] pb, input logic [255:0] p, input string req);
    int s = 0;
    while (s < 8) begin
      logic [7:0] m = '0;
      int e = s;
      while (1) begin
        m[e] = 1'b1;
        if (e == 7 || !pb[e]) break;
        e++;
      end
      chk(req, grp_valid, 1'b1);
      chk(req, grp_mask, m);
      chk("R7", grp_data, p);
      chk("R8", fp_ready, 1'b0);
      grp_accept = 1'b1;
      tick();
      grp_accept = 1'b0;
      s = e + 1;
    end
    chk("R8", fp_ready, 1'b1);
    chk("R8", grp_valid, 1'b0);
  endtask

  task automatic t_reset();
    fp_valid = 1'b0; grp_accept = 1'b0; fp_data = '0;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", grp_valid, 1'b0);
    chk("R1", fp_ready, 1'b1);
  endtask

  task automatic t_pattern(input logic [7:0] pb, input logic [31:0] seed, input string req);
    logic [255:0] p = mk_pkt(pb, seed);
    load_pkt(p, "R9");
    chk("R9", grp_mask[0], 1'b1);
    run_groups(pb, p, req);
  endtask

  task automatic t_stall_ignore();
    logic [255:0] p = mk_pkt(8'b0000_0110, 32'h77);
    logic [7:0] m0;
    load_pkt(p, "R9");
    m0 = grp_mask;
    chk("R2", m0, 8'h01);
    fp_valid = 1'b1; fp_data = ~p;
    repeat (3) begin
      tick();
      chk("R6", grp_mask, m0);
      chk("R6", grp_data, p);
      chk("R8", fp_ready, 1'b0);
    end
    fp_valid = 1'b0;
    run_groups(8'b0000_0110, p, "R2");
  endtask

  initial begin
    t_reset();
    t_pattern(8'hFF, 32'h11, "R4");
    t_pattern(8'h00, 32'h22, "R5");
    t_pattern(8'b1000_0000, 32'h33, "R3");
    t_pattern(8'b1010_0110, 32'h44, "R2");
    t_pattern(8'b0111_1111, 32'h55, "R3");
    t_stall_ignore();
    t_pattern(8'b0011_1011, 32'h66, "R2");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule